// File: doc/BRIEF.md
# Configurable GPIO Port Cell

This block is one port of general purpose pins. A 2-bit mode input sets how every implemented pin of the port behaves: input with an internal pull-up, open-drain output, or push-pull output. The cell holds the written port data, drives output-enable, output level and pull-up requests toward an external pad model, and returns the pad levels on its read bus. Pad electrics, drive strength and the interrupt controller lie outside the block.

Reads normally pass straight through from the pads. When the parallel-host input is high, reads instead return a copy of the pads captured on clock edges where the strobe is high. Each pin also has an edge detector behind a per-pin enable. A detected edge sets a pending bit, and that bit is held until the interrupt controller acknowledges it.

A port may implement fewer pins than its width. Missing pins read as a fixed level, drive nothing, request no pull-up and never raise an interrupt.

Top module: `gpio_port_cell`

## Requirements
- R1: While reset is held, and right after it, the data register is all ones. pad_out then shows 1 on every implemented pin, and irq_pending and irq_out are 0.
- R2: wr_en high at a rising clock edge loads wr_data into the data register. From that edge on, pad_out equals the data register on implemented pins.
- R3: mode 2'b00 (input with pull-up) and 2'b11 (treated the same) give pad_oe=0 and pad_pu=1. mode 2'b01 (open-drain) gives pad_oe = inverted data and pad_pu=0. mode 2'b10 (push-pull) gives pad_oe=1 and pad_pu=0.
- R4: With par_host_en low, rd_data follows pad_in in the same cycle, with no clock in between.
- R5: With par_host_en high, rd_data returns the pad_in value captured at the most recent rising edge where both par_host_en and strobe were high. Between such edges the value is held.
- R6: Pins at index IMPL_BITS and above read UNUSED_LEVEL on rd_data, show 0 on pad_out, pad_oe and pad_pu, and never become pending.
- R7: With irq_fall=0, a rising edge seen between two clock samples on an enabled pin sets that pin's irq_pending bit at the second sample. With irq_fall=1, a falling edge does the same.
- R8: An edge on a pin whose irq_en bit is 0 leaves its pending bit unchanged.
- R9: A pending bit stays set until a clock edge with its irq_ack bit high clears it. If a new qualifying edge arrives at that same clock edge, the bit stays set.
- R10: irq_out is high exactly when some irq_pending bit is high.
- R11: A pad level that differs from the reset-time sample at the first clock after reset does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Port drive mode |
| wr_en | input | 1 | Load wr_data into the data register |
| wr_data | input | W | Data to write |
| pad_in | input | W | Pad levels |
| par_host_en | input | 1 | Strobe-captured read mode |
| strobe | input | 1 | Capture strobe used in parallel-host mode |
| irq_en | input | W | Per-pin interrupt enable |
| irq_fall | input | 1 | Edge select: 0 rising, 1 falling |
| irq_ack | input | W | Per-pin pending clear |
| pad_out | output | W | Output level to the pads |
| pad_oe | output | W | Per-pin output enable |
| pad_pu | output | W | Per-pin pull-up request |
| rd_data | output | W | Port read value |
| irq_pending | output | W | Per-pin pending interrupts |
| irq_out | output | 1 | Any interrupt pending |

## Verification
The bench first holds the pads low through reset with falling-edge interrupts enabled. A cell that took the reset value of its edge history as a real sample would raise a false interrupt on the first cycle. The bench then makes a pin's edge land on the same clock edge as its acknowledge. A design that lets the clear win would lose that interrupt. It also checks that no ack leaves a pending bit set, and that an edge on a disabled pin sets nothing. In parallel-host mode, the pads keep moving while the strobe is low. A read path that stayed transparent would show those changes instead of the held capture. The bench uses a port with seven implemented pins, so the top pin must read the fixed level and never drive, pull up or interrupt.

// File: rtl/gpio_port_cell.sv
module gpio_port_cell #(
  parameter int W = 8,
  parameter int IMPL_BITS = 8,
  parameter logic UNUSED_LEVEL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pad_in,
  input  logic         par_host_en,
  input  logic         strobe,
  input  logic [W-1:0] irq_en,
  input  logic         irq_fall,
  input  logic [W-1:0] irq_ack,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] irq_pending,
  output logic         irq_out
);
  localparam logic [W-1:0] IMPL = {W{1'b1}} >> (W - IMPL_BITS);
  localparam logic [1:0] MODE_OD   = 2'b01;
  localparam logic [1:0] MODE_CMOS = 2'b10;

  logic [W-1:0] data_q, cap_q, prev_q, pend_q, edge_hit, oe_raw;
  logic         seen_q;

  assign edge_hit = (irq_fall ? (prev_q & ~pad_in) : (~prev_q & pad_in))
                    & irq_en & IMPL & {W{seen_q}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
      cap_q  <= '0;
      prev_q <= '1;
      seen_q <= 1'b0;
      pend_q <= '0;
    end else begin
      if (wr_en) data_q <= wr_data;
      if (par_host_en && strobe) cap_q <= pad_in;
      prev_q <= pad_in;
      seen_q <= 1'b1;
      pend_q <= ((pend_q & ~irq_ack) | edge_hit) & IMPL;
    end
  end

  always_comb begin
    case (mode)
      MODE_CMOS: oe_raw = '1;
      MODE_OD:   oe_raw = ~data_q;
      default:   oe_raw = '0;
    endcase
  end

  assign pad_out     = data_q & IMPL;
  assign pad_oe      = oe_raw & IMPL;
  assign pad_pu      = (mode == MODE_OD || mode == MODE_CMOS) ? '0 : IMPL;
  assign rd_data     = ((par_host_en ? cap_q : pad_in) & IMPL)
                       | ({W{UNUSED_LEVEL}} & ~IMPL);
  assign irq_pending = pend_q;
  assign irq_out     = |pend_q;
endmodule

// File: rtl/gpio_port_cell_chk.sv
module gpio_port_cell_chk #(
  parameter int W = 8,
  parameter int IMPL_BITS = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         par_host_en,
  input logic         strobe,
  input logic [W-1:0] irq_en,
  input logic [W-1:0] irq_ack,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] irq_pending
);
  localparam logic [W-1:0] HI = ~({W{1'b1}} >> (W - IMPL_BITS));

  a_r3_od_never_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> (pad_oe & pad_out) == '0);

  a_r9_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(irq_pending & ~irq_ack) & ~irq_pending) == '0);

  a_r8_only_enabled_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pending & ~$past(irq_pending) & ~$past(irq_en)) == '0);

  a_r6_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pending | pad_oe) & HI) == '0);

  a_r5_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    (par_host_en && !strobe) |=> (!par_host_en || rd_data == $past(rd_data)));
endmodule

bind gpio_port_cell gpio_port_cell_chk #(.W(W), .IMPL_BITS(IMPL_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .par_host_en(par_host_en),
  .strobe(strobe), .irq_en(irq_en), .irq_ack(irq_ack), .pad_out(pad_out),
  .pad_oe(pad_oe), .rd_data(rd_data), .irq_pending(irq_pending)
);

// File: tb/gpio_port_cell_bench.sv
`timescale 1ns/1ps
module gpio_port_cell_bench;
  localparam int W = 8;
  localparam int NB = 7;
  localparam logic UL = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wr_en = 1'b0, par_host_en = 1'b0, strobe = 1'b0, irq_fall = 1'b1;
  logic [W-1:0] wr_data = '0, pad_in = '0, irq_en = '1, irq_ack = '0;
  logic [W-1:0] pad_out, pad_oe, pad_pu, rd_data, irq_pending;
  logic irq_out;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port_cell #(.W(W), .IMPL_BITS(NB), .UNUSED_LEVEL(UL)) u_gpio_port_cell (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .pad_in(pad_in), .par_host_en(par_host_en), .strobe(strobe),
    .irq_en(irq_en), .irq_fall(irq_fall), .irq_ack(irq_ack),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .rd_data(rd_data),
    .irq_pending(irq_pending), .irq_out(irq_out));

  logic [W-1:0] m_data, m_cap, m_prev, m_pend;
  bit m_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '1; m_cap = '0; m_prev = '1; m_pend = '0; m_seen = 0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        bit hit;
        hit = m_seen && irq_en[i] &&
              (irq_fall ? (m_prev[i] && !pad_in[i]) : (!m_prev[i] && pad_in[i]));
        m_pend[i] = (m_pend[i] && !irq_ack[i]) || hit;
      end
      if (wr_en) m_data = wr_data;
      if (par_host_en && strobe) m_cap = pad_in;
      m_prev = pad_in;
      m_seen = 1;
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [W-1:0] e_out, e_oe, e_pu, e_rd;
    for (int i = 0; i < W; i++) begin
      bit impl;
      impl = (i < NB);
      e_out[i] = impl && m_data[i];
      e_oe[i]  = impl && (mode == 2'b10 || (mode == 2'b01 && !m_data[i]));
      e_pu[i]  = impl && (mode == 2'b00 || mode == 2'b11);
      e_rd[i]  = !impl ? UL : (par_host_en ? m_cap[i] : pad_in[i]);
    end
    chk("R2 pad_out", pad_out, e_out);
    chk("R3 pad_oe", pad_oe, e_oe);
    chk("R3 pad_pu", pad_pu, e_pu);
    chk(par_host_en ? "R5 rd_data" : "R4 rd_data", rd_data, e_rd);
    chk("R7 irq_pending", irq_pending, m_pend);
    chk("R10 irq_out", {7'd0, irq_out}, {7'd0, |m_pend});
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pad_out in reset", pad_out, 8'h7F);
    chk("R1 pending in reset", irq_pending, 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R11 no edge from reset sample", irq_pending, 8'h00);
    chk("R1 pad_out after reset", pad_out, 8'h7F);
    tick();
    chk("R11 still quiet", irq_pending, 8'h00);

    mode = 2'b10; pad_in = 8'hFF;
    tick();
    chk("R6 top pin no drive", pad_oe & 8'h80, 8'h00);
    chk("R6 top pin reads fixed level", rd_data & 8'h80, 8'h80);
    chk("R6 top pin never pending", irq_pending & 8'h80, 8'h00);

    irq_fall = 1'b0; irq_en = 8'h00; pad_in = 8'h00;
    tick(); pad_in = 8'h0F;
    tick();
    chk("R8 disabled edge ignored", irq_pending, 8'h00);

    irq_en = 8'h01; pad_in = 8'h00;
    tick(); pad_in = 8'h01;
    tick();
    chk("R7 rising edge pending", irq_pending, 8'h01);
    tick(); tick();
    chk("R9 held without ack", irq_pending, 8'h01);
    pad_in = 8'h00;
    tick(); pad_in = 8'h01; irq_ack = 8'h01;
    tick();
    chk("R9 new edge beats ack", irq_pending, 8'h01);
    irq_ack = 8'h01;
    tick(); irq_ack = 8'h00;
    tick();
    chk("R9 ack clears", irq_pending, 8'h00);

    par_host_en = 1'b1; strobe = 1'b1; pad_in = 8'h35;
    tick(); strobe = 1'b0; pad_in = 8'h4A;
    tick();
    chk("R5 held capture", rd_data, 8'hB5);
    par_host_en = 1'b0;

    for (int k = 0; k < 400; k++) begin
      tick();
      mode = 2'($urandom);
      wr_en = ($urandom % 3) == 0;
      wr_data = 8'($urandom);
      pad_in = 8'($urandom);
      par_host_en = ($urandom % 4) == 0;
      strobe = ($urandom % 2) == 0;
      irq_en = 8'($urandom);
      irq_fall = ($urandom % 8) == 0 ? ~irq_fall : irq_fall;
      irq_ack = 8'($urandom & $urandom & $urandom);
    end
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule